// File: doc/BRIEF.md
# Guarded Configuration Register with Latch Unlock

This block holds a single configuration byte for a serial memory with a built-in supervisor. The byte carries a write-protect enable, a two-bit watchdog interval select and a three-bit block-protect code, all treated as nonvolatile. It also holds two volatile write latches that guard every update. A bit-level 2-wire slave engine sits in front of the block. That engine reports start and stop conditions and hands over each received byte. It also asks for a byte whenever the master reads. The block tracks the frame, decides on each acknowledge it owns and serves register reads. It applies updates only after a three-step unlock.

An update is staged by the first data byte of a write aimed at word address FFFFh, and it takes effect only on the following stop. A committed update starts a store period, counted in clock ticks, that stands in for the nonvolatile write time. While that period runs, the device does not answer its slave address. The block-protect code is decoded into the lowest protected byte address of the memory array. Frames that target any other word address are flagged for the array logic, and the block leaves their data acknowledge alone.

The FSM states are IDLE, DEVSEL, ADDR_HI, ADDR_LO, WR_DATA, WR_EXTRA, RD_REG, RD_DONE, ARRAY and IGNORE. A start moves any state to DEVSEL, and a stop moves any state to IDLE. In DEVSEL, a matching slave address with the read bit set goes to RD_REG when the pointer is FFFFh and to ARRAY otherwise. A matching address with the write bit clear goes to ADDR_HI. A mismatching address, or any address while busy, goes to IGNORE. ADDR_HI always goes to ADDR_LO. ADDR_LO goes to WR_DATA when the address is FFFFh and to ARRAY otherwise. WR_DATA goes to WR_EXTRA. RD_REG goes to RD_DONE on the first read request.

Top module: `guarded_cfg_reg`

## Requirements
- R1: Only word address FFFFh reaches the register. After any other word address, `arr_sel` is high for the rest of the frame, data bytes produce no `ack_valid`, and the register does not change.
- R2: A register read returns {wpen, wd[1], wd[0], bp[1], bp[0], RWEL, WEL, bp[2]} from bit 7 down to bit 0. Reset leaves all of them 0.
- R3: A register write of 02h followed by a stop sets WEL. A register write of 06h followed by a stop sets RWEL, but only if WEL is already set; without WEL it has no effect.
- R4: A data byte commits only when WEL and RWEL are both set and bits 2:1 of the byte are 0. Otherwise the byte changes neither the configuration bits nor `busy`, except for the latch-setting codes of R3.
- R5: The first data byte of a register write gets `ack_ok`=1. Every later byte in the same frame gets `ack_valid`=1 with `ack_ok`=0.
- R6: A commit takes effect only on a stop. It clears WEL and RWEL and raises `busy` for exactly BUSY_TICKS cycles. The new configuration appears when `busy` falls. A repeated start in place of the stop discards the staged write.
- R7: While `busy` is high, the slave address byte gets `ack_valid`=1 with `ack_ok`=0, and the rest of the frame is ignored.
- R8: A register read yields exactly one byte on `tx_valid`. Further read requests in that frame produce no `tx_valid`.
- R9: The block-protect code bp={bp[2],bp[1],bp[0]} decodes as follows, with PAGE_BYTES-byte pages. Code 0 protects nothing (`prot_any`=0, `prot_base`=0). Codes 1 to 4 protect the top 1, 2, 4 or 8 pages, so `prot_base` = ARRAY_BYTES − pages×PAGE_BYTES. Codes 5 to 7 protect the whole array (`prot_base`=0).
- R10: `rst_n` (power cycle) clears WEL, RWEL, the frame state and the address pointer, and it keeps wpen, wd and bp. `cold_n` returns wpen, wd and bp to NV_DEFAULT.
- R11: In the slave address byte, bits 7:4 must equal DEV_ID (default 1010b) and bit 0 selects read (1) or write (0). A mismatch gets `ack_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-cycle reset (volatile state only) |
| cold_n | input | 1 | Active-low factory reset of the nonvolatile bits |
| bus_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen (one-cycle pulse) |
| rx_valid | input | 1 | A byte from the master is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | The engine needs the next read byte |
| ack_valid | output | 1 | This block decided the acknowledge of the last byte |
| ack_ok | output | 1 | 1 = acknowledge, 0 = no acknowledge |
| tx_valid | output | 1 | tx_byte holds a register read byte |
| tx_byte | output | 8 | Register image for the master |
| arr_sel | output | 1 | Current frame belongs to the memory array |
| busy | output | 1 | Nonvolatile store period running |
| wdog_sel | output | 2 | Watchdog interval select |
| wp_enable | output | 1 | Write-protect enable bit |
| prot_any | output | 1 | Some part of the array is protected |
| prot_base | output | ARR_AW | Lowest protected array byte address |

## Verification
The bench shortens BUSY_TICKS to 20, so the whole store period can be measured edge to edge and probed for refused slave addresses. It keeps PAGE_BYTES at 64, ARRAY_BYTES at 2048 and DEV_ID at 1010b. Under those values, each block-protect code gives a distinct base address (7C0h, 780h, 700h, 600h, 0), and every decode row can be compared with a hand-worked value.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

    localparam int WORD_AW = 16;
    localparam logic [WORD_AW-1:0] REG_WORD = 16'hFFFF;
    localparam logic [7:0] CODE_SET_WEL  = 8'h02;
    localparam logic [7:0] CODE_SET_RWEL = 8'h06;

    typedef enum logic [3:0] {
        FS_IDLE,
        FS_DEVSEL,
        FS_ADDR_HI,
        FS_ADDR_LO,
        FS_WR_DATA,
        FS_WR_EXTRA,
        FS_RD_REG,
        FS_RD_DONE,
        FS_ARRAY,
        FS_IGNORE
    } frame_st_t;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_SET_WEL,
        PK_SET_RWEL,
        PK_COMMIT
    } pend_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] wd;
        logic [2:0] bp;
    } nv_cfg_t;

    function automatic nv_cfg_t unpack_cfg(input logic [7:0] d);
        nv_cfg_t c;
        c.wpen = d[7];
        c.wd   = d[6:5];
        c.bp   = {d[0], d[4:3]};
        return c;
    endfunction

    function automatic logic [7:0] view_cfg(input nv_cfg_t c, input logic rw, input logic w);
        return {c.wpen, c.wd, c.bp[1:0], rw, w, c.bp[2]};
    endfunction

endpackage

// File: rtl/gcr_store_timer.sv
module gcr_store_timer #(
    parameter int TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(TICKS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !start |=> busy);                                 // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> !busy);                                         // R6

endmodule

// File: rtl/gcr_prot_decode.sv
module gcr_prot_decode #(
    parameter int PAGE_BYTES  = 64,
    parameter int ARRAY_BYTES = 2048,
    localparam int ARR_AW = $clog2(ARRAY_BYTES)
) (
    input  logic [2:0]        bp,
    output logic              prot_any,
    output logic [ARR_AW-1:0] prot_base
);
    localparam logic [ARR_AW:0] ARR_SPAN  = (ARR_AW+1)'(ARRAY_BYTES);
    localparam logic [ARR_AW:0] PAGE_SPAN = (ARR_AW+1)'(PAGE_BYTES);

    logic [ARR_AW:0] span;
    logic [ARR_AW:0] diff;

    always_comb begin
        span      = '0;
        diff      = '0;
        prot_any  = 1'b0;
        prot_base = '0;
        unique case (bp)
            3'd0: begin
                prot_any = 1'b0;
            end
            3'd1, 3'd2, 3'd3, 3'd4: begin
                prot_any = 1'b1;
                span     = PAGE_SPAN << (bp - 3'd1);
                if (span < ARR_SPAN) begin
                    diff      = ARR_SPAN - span;
                    prot_base = diff[ARR_AW-1:0];
                end
            end
            default: begin
                prot_any = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/gcr_frame_fsm.sv
module gcr_frame_fsm
    import gcr_pkg::*;
#(
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        tx_req,
    input  logic        busy,
    input  logic        wel,
    input  logic        rwel,
    input  logic [7:0]  reg_view,
    output logic        ack_valid,
    output logic        ack_ok,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        arr_sel,
    output logic        act,
    output pend_t       act_kind,
    output logic [7:0]  act_data
);
    frame_st_t          st_q, st_d;
    pend_t              pend_q, pend_d;
    logic [7:0]         stage_q, stage_d;
    logic [7:0]         hi_q, hi_d;
    logic [WORD_AW-1:0] ptr_q, ptr_d;
    logic               ackv_d, acko_d, txv_d, act_d;
    logic [7:0]         txb_d;

    function automatic pend_t classify(input logic [7:0] d, input logic w, input logic rw);
        if (w && rw && d[2:1] == 2'b00) return PK_COMMIT;
        else if (d == CODE_SET_WEL)    return PK_SET_WEL;
        else if (d == CODE_SET_RWEL && w) return PK_SET_RWEL;
        else                           return PK_NONE;
    endfunction

    // next state and decisions
    always_comb begin
        st_d    = st_q;
        pend_d  = pend_q;
        stage_d = stage_q;
        hi_d    = hi_q;
        ptr_d   = ptr_q;
        ackv_d  = 1'b0;
        acko_d  = 1'b0;
        txv_d   = 1'b0;
        txb_d   = 8'h00;
        act_d   = 1'b0;
        if (bus_stop) begin
            act_d  = (pend_q != PK_NONE);
            pend_d = PK_NONE;
            st_d   = FS_IDLE;
        end else if (bus_start) begin
            pend_d = PK_NONE;
            st_d   = FS_DEVSEL;
        end else if (rx_valid) begin
            unique case (st_q)
                FS_DEVSEL: begin
                    ackv_d = 1'b1;
                    if (busy || rx_byte[7:4] != DEV_ID) begin
                        st_d = FS_IGNORE;
                    end else begin
                        acko_d = 1'b1;
                        if (rx_byte[0])
                            st_d = (ptr_q == REG_WORD) ? FS_RD_REG : FS_ARRAY;
                        else
                            st_d = FS_ADDR_HI;
                    end
                end
                FS_ADDR_HI: begin
                    ackv_d = 1'b1;
                    acko_d = 1'b1;
                    hi_d   = rx_byte;
                    st_d   = FS_ADDR_LO;
                end
                FS_ADDR_LO: begin
                    ackv_d = 1'b1;
                    acko_d = 1'b1;
                    ptr_d  = {hi_q, rx_byte};
                    st_d   = ({hi_q, rx_byte} == REG_WORD) ? FS_WR_DATA : FS_ARRAY;
                end
                FS_WR_DATA: begin
                    ackv_d  = 1'b1;
                    acko_d  = 1'b1;
                    stage_d = rx_byte;
                    pend_d  = classify(rx_byte, wel, rwel);
                    st_d    = FS_WR_EXTRA;
                end
                FS_WR_EXTRA: begin
                    ackv_d = 1'b1;
                    acko_d = 1'b0;
                end
                FS_IDLE, FS_RD_REG, FS_RD_DONE, FS_ARRAY, FS_IGNORE: begin
                    st_d = st_q;
                end
            endcase
        end else if (tx_req && st_q == FS_RD_REG) begin
            txv_d = 1'b1;
            txb_d = reg_view;
            st_d  = FS_RD_DONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FS_IDLE;
            pend_q  <= PK_NONE;
            stage_q <= 8'h00;
            hi_q    <= 8'h00;
            ptr_q   <= '0;
        end else begin
            st_q    <= st_d;
            pend_q  <= pend_d;
            stage_q <= stage_d;
            hi_q    <= hi_d;
            ptr_q   <= ptr_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_ok    <= 1'b0;
            tx_valid  <= 1'b0;
            tx_byte   <= 8'h00;
            act       <= 1'b0;
            act_kind  <= PK_NONE;
            act_data  <= 8'h00;
        end else begin
            ack_valid <= ackv_d;
            ack_ok    <= acko_d;
            tx_valid  <= txv_d;
            tx_byte   <= txb_d;
            act       <= act_d;
            act_kind  <= pend_q;
            act_data  <= stage_q;
        end
    end

    assign arr_sel = (st_q == FS_ARRAY);

    AST_ONE_READ_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);                                           // R8
    AST_EXTRA_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == FS_WR_EXTRA && rx_valid && !bus_start && !bus_stop
        |=> ack_valid && !ack_ok);                                         // R5
    AST_ARRAY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        arr_sel && rx_valid && !bus_start && !bus_stop |=> !ack_valid);    // R1

endmodule

// File: rtl/guarded_cfg_reg.sv
module guarded_cfg_reg
    import gcr_pkg::*;
#(
    parameter int         PAGE_BYTES  = 64,
    parameter int         ARRAY_BYTES = 2048,
    parameter int         BUSY_TICKS  = 5000,
    parameter logic [3:0] DEV_ID      = 4'b1010,
    parameter logic [5:0] NV_DEFAULT  = 6'b000000,
    localparam int        ARR_AW      = $clog2(ARRAY_BYTES),
    localparam int        PAGE_AW     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              ack_valid,
    output logic              ack_ok,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              arr_sel,
    output logic              busy,
    output logic [1:0]        wdog_sel,
    output logic              wp_enable,
    output logic              prot_any,
    output logic [ARR_AW-1:0] prot_base
);
    nv_cfg_t    nv_q, nv_next_q;
    logic       wel_q, rwel_q;
    logic       act;
    pend_t      act_kind;
    logic [7:0] act_data;
    logic       tmr_start, tmr_done;
    logic [7:0] reg_view;

    assign reg_view  = view_cfg(nv_q, rwel_q, wel_q);
    assign tmr_start = act && (act_kind == PK_COMMIT);

    gcr_frame_fsm #(.DEV_ID(DEV_ID)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .busy      (busy),
        .wel       (wel_q),
        .rwel      (rwel_q),
        .reg_view  (reg_view),
        .ack_valid (ack_valid),
        .ack_ok    (ack_ok),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .arr_sel   (arr_sel),
        .act       (act),
        .act_kind  (act_kind),
        .act_data  (act_data)
    );

    gcr_store_timer #(.TICKS(BUSY_TICKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy),
        .done  (tmr_done)
    );

    gcr_prot_decode #(.PAGE_BYTES(PAGE_BYTES), .ARRAY_BYTES(ARRAY_BYTES)) u_prot (
        .bp        (nv_q.bp),
        .prot_any  (prot_any),
        .prot_base (prot_base)
    );

    // volatile write latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            rwel_q <= 1'b0;
        end else if (act) begin
            unique case (act_kind)
                PK_SET_WEL:  wel_q  <= 1'b1;
                PK_SET_RWEL: rwel_q <= 1'b1;
                PK_COMMIT: begin
                    wel_q  <= 1'b0;
                    rwel_q <= 1'b0;
                end
                PK_NONE: wel_q <= wel_q;
            endcase
        end
    end

    // nonvolatile image: survives rst_n, restored by cold_n
    always_ff @(posedge clk or negedge cold_n) begin
        if (!cold_n) begin
            nv_q      <= nv_cfg_t'(NV_DEFAULT);
            nv_next_q <= nv_cfg_t'(NV_DEFAULT);
        end else begin
            if (tmr_start) nv_next_q <= unpack_cfg(act_data);
            if (tmr_done)  nv_q      <= nv_next_q;
        end
    end

    assign wdog_sel  = nv_q.wd;
    assign wp_enable = nv_q.wpen;

    AST_NV_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!cold_n)
        !$past(tmr_done) |-> $stable(nv_q));                               // R6
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start |=> !wel_q && !rwel_q);                                  // R6
    AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        rwel_q |-> wel_q);                                                 // R3
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid && $past(busy) |-> !ack_ok);                             // R7
    AST_PROT_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        prot_any |-> prot_base[PAGE_AW-1:0] == '0);                        // R9

endmodule

// File: tb/guarded_cfg_reg_tb.sv
module guarded_cfg_reg_tb_top;
    localparam int ARR_AW = 11;
    localparam int TICKS  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0, cold_n = 1'b0;
    logic bus_start = 0, bus_stop = 0, rx_valid = 0, tx_req = 0;
    logic [7:0] rx_byte = 0;
    logic ack_valid, ack_ok, tx_valid, arr_sel, busy, wp_enable, prot_any;
    logic [7:0] tx_byte;
    logic [1:0] wdog_sel;
    logic [ARR_AW-1:0] prot_base;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    guarded_cfg_reg #(.BUSY_TICKS(TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cold_n(cold_n), .bus_start(bus_start),
        .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .arr_sel(arr_sel), .busy(busy), .wdog_sel(wdog_sel), .wp_enable(wp_enable),
        .prot_any(prot_any), .prot_base(prot_base));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) bus_start = 1; @(negedge clk) bus_start = 0;
    endtask
    task automatic pulse_stop();
        @(negedge clk) bus_stop = 1; @(negedge clk) bus_stop = 0;
        repeat (3) @(negedge clk);
    endtask
    task automatic send(input logic [7:0] b, input bit ev, input bit eo, input string req);
        @(negedge clk) begin rx_valid = 1; rx_byte = b; end
        @(negedge clk) rx_valid = 0;
        check(ack_valid == ev, req, ack_valid, ev);
        if (ev) check(ack_ok == eo, req, ack_ok, eo);
    endtask
    task automatic fetch(input bit ev, input logic [7:0] eb, input string req);
        @(negedge clk) tx_req = 1;
        @(negedge clk) tx_req = 0;
        check(tx_valid == ev, req, tx_valid, ev);
        if (ev) check(tx_byte == eb, req, tx_byte, eb);
    endtask
    task automatic reg_write(input logic [7:0] d);
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'hFF, 1, 1, "R1");
        send(8'hFF, 1, 1, "R1"); send(d, 1, 1, "R5"); pulse_stop();
    endtask
    task automatic reg_read(input logic [7:0] exp, input string req);
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'hFF, 1, 1, "R1");
        send(8'hFF, 1, 1, "R1"); pulse_start(); send(8'hA1, 1, 1, "R11");
        fetch(1, exp, req); pulse_stop();
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask
    task automatic commit(input logic [7:0] d);
        reg_write(8'h02); reg_write(8'h06); reg_write(d); wait_idle();
    endtask

    task automatic t_reset();
        check(!busy && !ack_valid && !tx_valid, "R2", busy, 0);
        check(wdog_sel == 0 && !wp_enable && !prot_any, "R10", {wdog_sel, wp_enable, prot_any}, 0);
        reg_read(8'h00, "R2");
    endtask
    task automatic t_latches();
        reg_write(8'h06); reg_read(8'h00, "R3 rwel without wel");
        reg_write(8'h02); reg_read(8'h02, "R3 wel");
        reg_write(8'h06); reg_read(8'h06, "R3 rwel");
    endtask
    task automatic t_commit();
        int cnt = 0;
        reg_write(8'h82);
        check(!busy, "R4 bad payload", busy, 0);
        reg_read(8'h06, "R4 bad payload");
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'hFF, 1, 1, "R1");
        send(8'hFF, 1, 1, "R1"); send(8'hA9, 1, 1, "R5");
        @(negedge clk) bus_stop = 1; @(negedge clk) bus_stop = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (busy) cnt++;
            if (!busy && cnt > 0) break;
        end
        check(cnt == TICKS, "R6 busy length", cnt, TICKS);
        check(wdog_sel == 2'b01 && wp_enable, "R6 new cfg", {wp_enable, wdog_sel}, 3'b101);
        check(prot_any && prot_base == 0, "R9 code5 whole", prot_base, 0);
        reg_read(8'hA9, "R6 latches cleared");
        reg_write(8'h00); check(!busy, "R4 locked", busy, 0);
        reg_read(8'hA9, "R4 locked");
    endtask
    task automatic t_busy_refuse();
        reg_write(8'h02); reg_write(8'h06); reg_write(8'h08);
        check(busy, "R7 busy", busy, 1);
        pulse_start(); send(8'hA0, 1, 0, "R7"); send(8'hFF, 0, 0, "R7 ignored");
        pulse_stop(); wait_idle();
        check(prot_any && prot_base == 11'h7C0, "R9 code1", prot_base, 11'h7C0);
    endtask
    task automatic t_extra_and_restart();
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'hFF, 1, 1, "R1");
        send(8'hFF, 1, 1, "R1"); send(8'h02, 1, 1, "R5"); send(8'h55, 1, 0, "R5 extra");
        pulse_stop(); reg_read(8'h0A, "R5 wel set");
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'hFF, 1, 1, "R1");
        send(8'hFF, 1, 1, "R1"); send(8'h06, 1, 1, "R5");
        pulse_start(); pulse_stop();
        reg_read(8'h0A, "R6 restart discards");
    endtask
    task automatic t_decode();
        commit(8'h10); check(prot_base == 11'h780 && prot_any, "R9 code2", prot_base, 11'h780);
        commit(8'h18); check(prot_base == 11'h700 && prot_any, "R9 code3", prot_base, 11'h700);
        commit(8'h01); check(prot_base == 11'h600 && prot_any, "R9 code4", prot_base, 11'h600);
        commit(8'h00); check(!prot_any && prot_base == 0, "R9 code0", prot_any, 0);
    endtask
    task automatic t_array_and_id();
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'h00, 1, 1, "R1");
        send(8'h10, 1, 1, "R1");
        check(arr_sel, "R1 arr_sel", arr_sel, 1);
        send(8'h02, 0, 0, "R1 no ack"); pulse_stop();
        reg_read(8'h00, "R1 unchanged");
        pulse_start(); send(8'h50, 1, 0, "R11 id mismatch"); pulse_stop();
        pulse_start(); send(8'hA0, 1, 1, "R11"); send(8'hFF, 1, 1, "R1");
        send(8'hFF, 1, 1, "R1"); pulse_start(); send(8'hA1, 1, 1, "R11");
        fetch(1, 8'h00, "R8"); fetch(0, 8'h00, "R8 second"); pulse_stop();
    endtask
    task automatic t_power();
        commit(8'h68); reg_write(8'h02); reg_read(8'h6A, "R10 pre");
        @(negedge clk) rst_n = 0; @(negedge clk) rst_n = 1;
        reg_read(8'h68, "R10 survives power cycle");
        @(negedge clk) cold_n = 0; @(negedge clk) cold_n = 1;
        reg_read(8'h00, "R10 cold default");
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1; cold_n = 1;
                @(negedge clk);
                t_reset(); t_latches(); t_commit(); t_busy_refuse();
                t_extra_and_restart(); t_decode(); t_array_and_id(); t_power();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule